// File: doc/BRIEF.md
# Recursive-Doubling Reduction Engine

The engine folds a set of signed operands into one value with an associative operator chosen by a 2-bit opcode: wrapping sum, signed minimum or signed maximum. The operands are spread over a power-of-two number of lanes. After a start pulse, every lane first folds its own operand stream at one operand per cycle. The lane counts may differ, so a caller can split M operands as floor(M/N) per lane plus one extra on M mod N lanes. The lanes then merge their partial values in log2(N) pairwise steps. In each step, half of the lanes that are still live pass their value to a partner whose index differs in one bit. When the steps are finished, lane 0 holds the global value.

The caller presents the next operand for each lane on that lane's data slice. It moves to the following operand once the engine has raised the lane's take strobe across a clock edge. Every lane's partial register is visible on a debug bus, next to the current merge step and a flag that marks the merge phase. The result port shows lane 0 and is valid in the single cycle in which done is high. It keeps that value until the next accepted start.

Top module: `rdbl_reduce`

## Requirements
- R1: After reset the engine is idle: busy, done and every lane take strobe are 0.
- R2: A start pulse seen while idle latches the opcode and the per-lane operand counts, and busy is 1 from the next cycle.
- R3: In local cycle c (c = 1 for the first busy cycle), lane i raises its take strobe exactly when c is at most its latched count, and the operand on its data slice is folded in at that edge. No take strobe is high outside the local phase.
- R4: A lane with a count of zero contributes the identity value: 0 for sum, 0x7FFF (most positive, at W=16) for min, 0x8000 (most negative) for max.
- R5: Opcode 2'b00 gives a sum modulo 2^W, 2'b01 gives the signed minimum, 2'b10 gives the signed maximum, and the spare code 2'b11 behaves as sum.
- R6: In merge step j (j from 0), a lane whose index has bit j set and all lower bits clear sends to the lane that has bit j cleared and the same upper bits. The receiver folds in the value and the other lanes hold theirs. So once merging ends, lane i holds the fold of lanes i to i+2^t-1, where t is the number of trailing zeros of i (lane 0 folds all lanes).
- R7: With K the largest latched count and n = log2(N), done is high for exactly one cycle, K+n+2 cycles after the start edge, and busy stays 1 from the start edge up to and including that cycle.
- R8: At done, result equals the global fold of all operands, and it stays unchanged while the engine is idle.
- R9: A start pulse while busy is ignored: the opcode, the counts and the timing of the run in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reduction when idle |
| opSel | input | 2 | Operator code: 00 sum, 01 min, 10 max, 11 sum |
| laneCount | input | LANES*CW | Per-lane operand counts, lane i at bits [i*CW +: CW] |
| laneData | input | LANES*W | Current operand of each lane, lane i at bits [i*W +: W] |
| laneTake | output | LANES | Lane i consumes its operand at the next edge |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Global value (lane 0 partial) |
| dbgPartials | output | LANES*W | Partial register of every lane |
| dbgStep | output | 8 | Current merge step index |
| dbgCombine | output | 1 | Merge phase active |

## Verification
A wrong remaining-count register in a lane shows up on that lane's take strobe in the same cycle it goes wrong, and it stretches or shortens the local phase, which moves done off its K+n+2 cycle. A pairing error in the merge network does not move the timing. It only corrupts the partial registers, so the debug bus is compared lane by lane at done against the subtree folds: a sender that was wrongly overwritten, or a receiver that read the wrong partner, shows up there even when lane 0 happens to be right. An identity or operator-decoding fault only shows when a lane with a zero count, a spare opcode or a run that wraps is given, so each of these cases has a run of its own.

// File: rtl/rdbl_pkg.sv
package rdbl_pkg;

  localparam int STEP_BITS = 8;

  typedef enum logic [1:0] {
    OP_SUM = 2'b00,
    OP_MIN = 2'b01,
    OP_MAX = 2'b10,
    OP_ALT = 2'b11
  } redOp_e;

  typedef struct packed {
    logic                 init;
    logic                 localEn;
    logic                 combEn;
    logic [STEP_BITS-1:0] step;
  } strobe_t;

  // number of merge steps in which lane v receives (lane 0 receives in all)
  function automatic int trailZeros(input int v, input int lim);
    int t;
    t = 0;
    while (t < lim && ((v >> t) & 1) == 0) t++;
    return t;
  endfunction

endpackage

// File: rtl/rdbl_control.sv
module rdbl_control
  import rdbl_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    pending,
  output strobe_t ctl,
  output logic    busy,
  output logic    done
);

  typedef enum logic [1:0] {S_IDLE, S_LOCAL, S_MERGE, S_FIN} phase_e;

  localparam logic [STEP_BITS-1:0] LAST_STEP = STEP_BITS'(STEPS - 1);

  phase_e               phase;
  logic [STEP_BITS-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (phase)
        S_IDLE:  if (start) phase <= S_LOCAL;
        S_LOCAL: if (!pending) begin
                   phase   <= S_MERGE;
                   stepCnt <= '0;
                 end
        S_MERGE: if (stepCnt == LAST_STEP) phase <= S_FIN;
                 else stepCnt <= stepCnt + 1'b1;
        S_FIN:   phase <= S_IDLE;
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.init    = (phase == S_IDLE) && start;
    ctl.localEn = (phase == S_LOCAL);
    ctl.combEn  = (phase == S_MERGE);
    ctl.step    = stepCnt;
  end

  assign busy = (phase != S_IDLE);
  assign done = (phase == S_FIN);

endmodule

// File: rtl/rdbl_datapath.sv
module rdbl_datapath
  import rdbl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 16,
  parameter int CW    = 4,
  parameter int STEPS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ctl,
  input  logic [1:0]       opSel,
  input  logic [LANES*CW-1:0] laneCount,
  input  logic [LANES*W-1:0]  laneData,
  output logic [LANES-1:0] laneTake,
  output logic             pending,
  output logic [LANES*W-1:0]  partialsFlat
);

  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [1:0]    opReg;
  logic [W-1:0]  partArr [LANES];
  logic [CW-1:0] remArr  [LANES];
  logic [W-1:0]  peerCand [LANES][STEPS];

  function automatic logic [W-1:0] identOf(input logic [1:0] op);
    case (op)
      OP_MIN:  return MOST_POS;
      OP_MAX:  return MOST_NEG;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] fold(input logic [1:0] op,
                                        input logic [W-1:0] a,
                                        input logic [W-1:0] b);
    case (op)
      OP_MIN:  return ($signed(b) < $signed(a)) ? b : a;
      OP_MAX:  return ($signed(b) > $signed(a)) ? b : a;
      default: return a + b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) opReg <= OP_SUM;
    else if (ctl.init) opReg <= opSel;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int RECV_STEPS = trailZeros(g, STEPS);

    logic [W-1:0] peerVal;
    logic         recvNow;

    for (genvar s = 0; s < STEPS; s++) begin : g_peer
      if (RECV_STEPS > s) begin : g_link
        assign peerCand[g][s] = partArr[g + (1 << s)];
      end else begin : g_none
        assign peerCand[g][s] = '0;
      end
    end

    always_comb begin
      peerVal = '0;
      for (int s = 0; s < STEPS; s++)
        if (ctl.step == STEP_BITS'(s)) peerVal = peerCand[g][s];
    end

    assign recvNow     = ctl.combEn && (int'(ctl.step) < RECV_STEPS);
    assign laneTake[g] = ctl.localEn && (remArr[g] != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        partArr[g] <= '0;
        remArr[g]  <= '0;
      end else if (ctl.init) begin
        partArr[g] <= identOf(opSel);
        remArr[g]  <= laneCount[g*CW +: CW];
      end else if (laneTake[g]) begin
        partArr[g] <= fold(opReg, partArr[g], laneData[g*W +: W]);
        remArr[g]  <= remArr[g] - 1'b1;
      end else if (recvNow) begin
        partArr[g] <= fold(opReg, partArr[g], peerVal);
      end
    end

    assign partialsFlat[g*W +: W] = partArr[g];
  end

  assign pending = |laneTake;

endmodule

// File: rtl/rdbl_reduce.sv
module rdbl_reduce
  import rdbl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 16,
  parameter int CW    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          opSel,
  input  logic [LANES*CW-1:0] laneCount,
  input  logic [LANES*W-1:0]  laneData,
  output logic [LANES-1:0]    laneTake,
  output logic                busy,
  output logic                done,
  output logic [W-1:0]        result,
  output logic [LANES*W-1:0]  dbgPartials,
  output logic [7:0]          dbgStep,
  output logic                dbgCombine
);

  localparam int STEPS = $clog2(LANES);

  strobe_t ctl;
  logic    pending;

  rdbl_control #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pending(pending),
    .ctl(ctl), .busy(busy), .done(done)
  );

  rdbl_datapath #(.LANES(LANES), .W(W), .CW(CW), .STEPS(STEPS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSel(opSel),
    .laneCount(laneCount), .laneData(laneData),
    .laneTake(laneTake), .pending(pending), .partialsFlat(dbgPartials)
  );

  assign result     = dbgPartials[W-1:0];
  assign dbgStep    = 8'(ctl.step);
  assign dbgCombine = ctl.combEn;

endmodule

// File: rtl/rdbl_reduce_chk.sv
module rdbl_reduce_chk #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [LANES-1:0] laneTake,
  input logic             dbgCombine,
  input logic [W-1:0]     result
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R7
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R7
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(start)); // R2
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (laneTake == '0)); // R3
  AST_MERGE_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN) dbgCombine |-> (laneTake == '0)); // R3
  AST_MERGE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN) dbgCombine |-> (busy && !done)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN) (!busy && $past(!busy) && !$past(start)) |-> $stable(result)); // R8

endmodule

bind rdbl_reduce rdbl_reduce_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .laneTake(laneTake), .dbgCombine(dbgCombine), .result(result)
);

// File: tb/test_rdbl_reduce.sv
module test_rdbl_reduce;

  localparam int LANES = 8;
  localparam int W     = 16;
  localparam int CW    = 4;
  localparam int NSTEP = 3;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [1:0]          opSel = 2'b00;
  logic [LANES*CW-1:0] laneCount = '0;
  logic [LANES*W-1:0]  laneData = '0;
  logic [LANES-1:0]    laneTake;
  logic                busy, done;
  logic [W-1:0]        result;
  logic [LANES*W-1:0]  dbgPartials;
  logic [7:0]          dbgStep;
  logic                dbgCombine;

  rdbl_reduce #(.LANES(LANES), .W(W), .CW(CW)) i_rdbl_reduce (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .laneCount(laneCount), .laneData(laneData), .laneTake(laneTake),
    .busy(busy), .done(done), .result(result), .dbgPartials(dbgPartials),
    .dbgStep(dbgStep), .dbgCombine(dbgCombine)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int seed = 7;

  // behavioural reference state
  logic [W-1:0] q [LANES][$];
  int           cnt [LANES];
  logic [W-1:0] expLane [LANES];
  logic [W-1:0] expTop;
  logic [LANES-1:0] prevTake = '0;
  bit  active = 0;
  bit  startPending = 0;
  int  cyc = 0;
  int  total = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] refOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    if (op == 2'b01) return ($signed(a) <= $signed(b)) ? a : b;
    if (op == 2'b10) return ($signed(a) >= $signed(b)) ? a : b;
    return a + b;
  endfunction

  function automatic logic [W-1:0] refIdent(input logic [1:0] op);
    if (op == 2'b01) return 16'h7FFF;
    if (op == 2'b10) return 16'h8000;
    return 16'h0000;
  endfunction

  function automatic logic [W-1:0] nextRand();
    seed = seed * 1103515245 + 12345;
    return seed[23:8];
  endfunction

  task automatic tick();
    @(negedge clk);
    if (startPending) begin active = 1; cyc = 0; startPending = 0; end
    if (active) cyc++;
    for (int i = 0; i < LANES; i++) begin
      if (prevTake[i] && q[i].size() > 0) void'(q[i].pop_front());
      laneData[i*W +: W] = (q[i].size() > 0) ? q[i][0] : '0;
    end
    check("R7 busy", 64'(busy), 64'(active && cyc <= total));
    check("R7 done", 64'(done), 64'(active && cyc == total));
    for (int i = 0; i < LANES; i++)
      check("R3 take", 64'(laneTake[i]), 64'(active && cyc <= cnt[i]));
    if (active && cyc == total) begin
      check("R8 result", 64'(result), 64'(expTop));
      for (int i = 0; i < LANES; i++)
        check("R6 partial", 64'(dbgPartials[i*W +: W]), 64'(expLane[i]));
      active = 0;
    end
    prevTake = laneTake;
  endtask

  // fill < 0 : random operands, otherwise every operand equals fill
  task automatic runCase(input logic [1:0] op, input int c [LANES], input int fill, input bit sneak);
    logic [W-1:0] local_r [LANES];
    int k;
    k = 0;
    for (int i = 0; i < LANES; i++) begin
      q[i].delete();
      cnt[i] = c[i];
      if (c[i] > k) k = c[i];
      local_r[i] = refIdent(op);
      for (int j = 0; j < c[i]; j++) begin
        logic [W-1:0] v;
        v = (fill < 0) ? nextRand() : W'(fill);
        q[i].push_back(v);
        local_r[i] = refOp(op, local_r[i], v);
      end
      laneCount[i*CW +: CW] = CW'(c[i]);
    end
    for (int i = 0; i < LANES; i++) begin
      int span;
      span = 1;
      while (span < LANES && ((i / span) % 2) == 0) span *= 2;
      expLane[i] = local_r[i];
      for (int j = i + 1; j < i + span; j++) expLane[i] = refOp(op, expLane[i], local_r[j]);
    end
    expTop = expLane[0];
    total = k + NSTEP + 2;
    opSel = op;
    start = 1'b1;
    startPending = 1;
    tick();
    start = 1'b0;
    while (active) begin
      if (sneak && cyc == 2) begin
        start = 1'b1; opSel = ~op; laneCount = '1;   // R9 ignored while busy
        tick();
        start = 1'b0;
      end else tick();
    end
    repeat (3) tick();
    check("R8 held", 64'(result), 64'(expTop));
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c [LANES];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 take", 64'(laneTake), 0);
    tick();
    // R2 R5 sum, equal counts
    c = '{3, 3, 3, 3, 3, 3, 3, 3};
    runCase(2'b00, c, -1, 0);
    // R5 min, uneven split of 13 operands
    c = '{2, 2, 2, 2, 2, 1, 1, 1};
    runCase(2'b01, c, -1, 0);
    // R4 max with empty lanes
    c = '{0, 4, 0, 1, 0, 0, 2, 0};
    runCase(2'b10, c, -1, 0);
    // R4 all lanes empty: identity in each operator
    c = '{0, 0, 0, 0, 0, 0, 0, 0};
    runCase(2'b00, c, -1, 0);
    runCase(2'b01, c, -1, 0);
    runCase(2'b10, c, -1, 0);
    // R5 wrapping sum: 16 x 0xF000 wraps to 0
    c = '{2, 2, 2, 2, 2, 2, 2, 2};
    runCase(2'b00, c, 16'hF000, 0);
    // R5 spare code behaves as sum
    c = '{1, 5, 2, 0, 3, 1, 4, 2};
    runCase(2'b11, c, -1, 0);
    // R9 start while busy
    c = '{4, 1, 3, 2, 0, 5, 1, 2};
    runCase(2'b01, c, -1, 1);
    // R3 largest count on one lane
    c = '{0, 0, 0, 0, 0, 0, 0, 15};
    runCase(2'b10, c, -1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule